// File: doc/BRIEF.md
# Gamma Breathing PWM Engine

This block drives a single LED current sink with a repeating "breathing" envelope that needs no software once it has been set up. The envelope has five phases: a one-time holdoff delay, a 32-step ramp up that follows a gamma-1.8 curve, a full-on dwell, a mirrored 32-step ramp down, and a dark gap. After the gap the waveform loops back to the ramp up. The holdoff is not part of the loop.

Each phase length is set by a small power-of-two time code. Lengths are counted in pulses of the `tick` input. One time unit is 2^UNIT_LOG2 ticks, which is 32 ticks by default. The caller's time base sets this unit to the nominal 0.13 s step. The five codes on the input pins are captured only by the `upd` strobe, and that strobe also restarts the envelope at its holdoff. Raising `mode_en` also restarts the envelope, using the codes captured last. The current envelope level is turned into a 256-step PWM gate on `sink_en`.

Top module: `breath_pwm_engine`

## Requirements
- R1: While `mode_en` is low, `sink_en` stays low. After reset all captured codes are zero.
- R2: A restart runs the holdoff first, with `sink_en` low throughout. Its length is 0 for `delay_code` 0, and 2^(k-1) units for `delay_code` k from 1 to 10. The holdoff runs only after an `upd` strobe or a rising `mode_en`, never between loops.
- R3: The ramp up lasts 2^c units for `rise_code` c from 0 to 7. It is split into 32 equal steps. Step i (0..31) has duty G[i]/256, where G = 0,1,3,5,8,12,16,21,26,32,38,45,52,60,68,76,85,95,105,115,125,136,148,160,172,185,198,211,225,239,254,255.
- R4: During the dwell, `sink_en` is high on every cycle. The dwell length is 0 for `dwell_code` 0 and 2^(k-1) units for k from 1 to 8. A zero dwell skips straight to the ramp down.
- R5: The ramp down lasts 2^c units for `fall_code` c. Its step i has duty G[31-i]/256.
- R6: During the gap, `sink_en` is low. The gap length is 0 for `gap_code` 0 and 2^(k-1) units for k from 1 to 10. After the gap, or straight after the ramp down when the gap is zero, the envelope returns to the ramp up with no holdoff.
- R7: Changes on the code inputs have no effect until `upd` is pulsed. A pulse of `upd` captures all five codes and, while `mode_en` is high, restarts at the holdoff.
- R8: A rising `mode_en` restarts the envelope at the holdoff, using the codes captured by the last `upd`.
- R9: Codes above the largest listed value saturate: `delay_code` and `gap_code` above 10 act as 10, and `dwell_code` above 8 acts as 8.
- R10: For a held duty of d/256, `sink_en` is high on exactly d of any 256 consecutive cycles, and on all 256 during the dwell. The PWM counter runs freely from reset, and `sink_en` is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base pulse. 2^UNIT_LOG2 pulses make one time unit |
| mode_en | input | 1 | Enables the engine. A rising edge restarts the envelope |
| upd | input | 1 | Captures the codes and restarts the envelope |
| delay_code | input | 4 | Holdoff length code |
| rise_code | input | 3 | Ramp-up length code |
| dwell_code | input | 4 | Full-on dwell length code |
| fall_code | input | 3 | Ramp-down length code |
| gap_code | input | 4 | Dark gap length code |
| sink_en | output | 1 | Registered PWM gate for the current sink |

## Verification
Some rules are checked by the assertions on every cycle:
- the output is dark in the holdoff, in the gap and while disabled, and fully on in the dwell;
- the duty never falls during the ramp up and never rises during the ramp down;
- the holdoff is entered only after a strobe or a mode entry;
- the captured codes change only on a strobe.

Other properties can only be shown by the bench scenarios. These are the exact duty in each tick window against the gamma table, the phase lengths for each code, and the skipping of zero-length phases. The same goes for code saturation, the blocking of unstrobed code changes, and the reuse of the captured codes when the mode is entered again.

// File: rtl/breath_pkg.sv
package breath_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_HOLD = 3'd1,
    PH_RISE = 3'd2,
    PH_HIGH = 3'd3,
    PH_FALL = 3'd4,
    PH_LOW  = 3'd5
  } phase_t;

  localparam int RAMP_LOG2 = 5;

  // Gamma 1.8 duty curve in 1/256 steps, indexed by ramp step.
  function automatic logic [7:0] gamma_lut(input logic [4:0] idx);
    case (idx)
      5'd0:  return 8'd0;    5'd1:  return 8'd1;    5'd2:  return 8'd3;    5'd3:  return 8'd5;
      5'd4:  return 8'd8;    5'd5:  return 8'd12;   5'd6:  return 8'd16;   5'd7:  return 8'd21;
      5'd8:  return 8'd26;   5'd9:  return 8'd32;   5'd10: return 8'd38;   5'd11: return 8'd45;
      5'd12: return 8'd52;   5'd13: return 8'd60;   5'd14: return 8'd68;   5'd15: return 8'd76;
      5'd16: return 8'd85;   5'd17: return 8'd95;   5'd18: return 8'd105;  5'd19: return 8'd115;
      5'd20: return 8'd125;  5'd21: return 8'd136;  5'd22: return 8'd148;  5'd23: return 8'd160;
      5'd24: return 8'd172;  5'd25: return 8'd185;  5'd26: return 8'd198;  5'd27: return 8'd211;
      5'd28: return 8'd225;  5'd29: return 8'd239;  5'd30: return 8'd254;  default: return 8'd255;
    endcase
  endfunction

endpackage

// File: rtl/breath_len_decode.sv
module breath_len_decode #(
  parameter int CODE_W    = 4,
  parameter int MAX_CODE  = 10,
  parameter bit HAS_ZERO  = 1'b1,
  parameter int UNIT_LOG2 = 5,
  parameter int LEN_W     = 15
) (
  input  logic [CODE_W-1:0] code,
  output logic [LEN_W-1:0]  len_ticks
);

  logic [CODE_W-1:0] k;

  // Saturate reserved codes only when the field can exceed its maximum.
  generate
    if (MAX_CODE < (2**CODE_W) - 1) begin : g_sat
      assign k = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
    end else begin : g_pass
      assign k = code;
    end
  endgenerate

  // Zero-capable fields: 0 -> none, k -> 2^(k-1) units. Ramp fields: c -> 2^c units.
  generate
    if (HAS_ZERO) begin : g_zero
      always_comb begin
        if (k == '0) len_ticks = '0;
        else         len_ticks = LEN_W'(1) << (UNIT_LOG2 + int'(k) - 1);
      end
    end else begin : g_ramp
      assign len_ticks = LEN_W'(1) << (UNIT_LOG2 + int'(k));
    end
  endgenerate

endmodule

// File: rtl/breath_seq.sv
module breath_seq
  import breath_pkg::*;
#(
  parameter int UNIT_LOG2 = 5,
  parameter int LEN_W     = 15,
  parameter int PWM_BITS  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_en,
  input  logic                upd,
  input  logic                tick,
  input  logic [LEN_W-1:0]    len_delay,
  input  logic [LEN_W-1:0]    len_rise,
  input  logic [LEN_W-1:0]    len_dwell,
  input  logic [LEN_W-1:0]    len_fall,
  input  logic [LEN_W-1:0]    len_gap,
  input  logic [2:0]          rise_code,
  input  logic [2:0]          fall_code,
  output phase_t              phase,
  output logic [PWM_BITS:0]   duty,
  output logic                mode_q
);

  localparam int STEP_SHIFT = UNIT_LOG2 - RAMP_LOG2;

  logic [LEN_W-1:0] tcnt;
  logic [LEN_W-1:0] cur_len;
  logic             last;
  logic             start;
  phase_t           next_phase;
  logic [LEN_W-1:0] up_pos;
  logic [LEN_W-1:0] dn_pos;

  always_comb begin
    case (phase)
      PH_HOLD: cur_len = len_delay;
      PH_RISE: cur_len = len_rise;
      PH_HIGH: cur_len = len_dwell;
      PH_FALL: cur_len = len_fall;
      PH_LOW:  cur_len = len_gap;
      default: cur_len = '0;
    endcase
  end

  assign last  = (tcnt == cur_len - LEN_W'(1));
  assign start = mode_en && (upd || !mode_q);

  // Successor of the current phase, skipping zero-length phases.
  always_comb begin
    case (phase)
      PH_HOLD: next_phase = PH_RISE;
      PH_RISE: next_phase = (len_dwell != '0) ? PH_HIGH : PH_FALL;
      PH_HIGH: next_phase = PH_FALL;
      PH_FALL: next_phase = (len_gap != '0) ? PH_LOW : PH_RISE;
      PH_LOW:  next_phase = PH_RISE;
      default: next_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      tcnt   <= '0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= mode_en;
      if (!mode_en) begin
        phase <= PH_IDLE;
        tcnt  <= '0;
      end else if (start) begin
        phase <= PH_HOLD;
        tcnt  <= '0;
      end else if (phase == PH_HOLD && len_delay == '0) begin
        phase <= PH_RISE;
        tcnt  <= '0;
      end else if (tick && phase != PH_IDLE) begin
        if (last) begin
          phase <= next_phase;
          tcnt  <= '0;
        end else begin
          tcnt <= tcnt + LEN_W'(1);
        end
      end
    end
  end

  // Ramp step = position / (ramp length / 32).
  assign up_pos = tcnt >> (STEP_SHIFT + int'(rise_code));
  assign dn_pos = tcnt >> (STEP_SHIFT + int'(fall_code));

  always_comb begin
    case (phase)
      PH_RISE: duty = (PWM_BITS+1)'(gamma_lut(up_pos[4:0])) << (PWM_BITS - 8);
      PH_FALL: duty = (PWM_BITS+1)'(gamma_lut(5'd31 - dn_pos[4:0])) << (PWM_BITS - 8);
      PH_HIGH: duty = (PWM_BITS+1)'(1) << PWM_BITS;
      default: duty = '0;
    endcase
  end

endmodule

// File: rtl/breath_pwm.sv
module breath_pwm #(
  parameter int PWM_BITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PWM_BITS:0] duty,
  output logic              sink_en
);

  logic [PWM_BITS-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      sink_en <= 1'b0;
    end else begin
      cnt     <= cnt + PWM_BITS'(1);
      sink_en <= ({1'b0, cnt} < duty);
    end
  end

endmodule

// File: rtl/breath_pwm_engine.sv
module breath_pwm_engine
  import breath_pkg::*;
#(
  parameter int UNIT_LOG2 = 5,
  parameter int PWM_BITS  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       mode_en,
  input  logic       upd,
  input  logic [3:0] delay_code,
  input  logic [2:0] rise_code,
  input  logic [3:0] dwell_code,
  input  logic [2:0] fall_code,
  input  logic [3:0] gap_code,
  output logic       sink_en
);

  localparam int LEN_W   = UNIT_LOG2 + 10;
  localparam int CODES_W = 18;

  logic [CODES_W-1:0] codes_q;
  logic [LEN_W-1:0]   len_delay, len_rise, len_dwell, len_fall, len_gap;
  phase_t             phase;
  logic [PWM_BITS:0]  duty;
  logic               mode_q;

  // Captured codes: {delay[17:14], rise[13:11], dwell[10:7], fall[6:4], gap[3:0]}.
  always_ff @(posedge clk) begin
    if (rst)      codes_q <= '0;
    else if (upd) codes_q <= {delay_code, rise_code, dwell_code, fall_code, gap_code};
  end

  breath_len_decode #(.CODE_W(4), .MAX_CODE(10), .HAS_ZERO(1'b1), .UNIT_LOG2(UNIT_LOG2), .LEN_W(LEN_W))
    u_dec_delay (.code(codes_q[17:14]), .len_ticks(len_delay));
  breath_len_decode #(.CODE_W(3), .MAX_CODE(7), .HAS_ZERO(1'b0), .UNIT_LOG2(UNIT_LOG2), .LEN_W(LEN_W))
    u_dec_rise (.code(codes_q[13:11]), .len_ticks(len_rise));
  breath_len_decode #(.CODE_W(4), .MAX_CODE(8), .HAS_ZERO(1'b1), .UNIT_LOG2(UNIT_LOG2), .LEN_W(LEN_W))
    u_dec_dwell (.code(codes_q[10:7]), .len_ticks(len_dwell));
  breath_len_decode #(.CODE_W(3), .MAX_CODE(7), .HAS_ZERO(1'b0), .UNIT_LOG2(UNIT_LOG2), .LEN_W(LEN_W))
    u_dec_fall (.code(codes_q[6:4]), .len_ticks(len_fall));
  breath_len_decode #(.CODE_W(4), .MAX_CODE(10), .HAS_ZERO(1'b1), .UNIT_LOG2(UNIT_LOG2), .LEN_W(LEN_W))
    u_dec_gap (.code(codes_q[3:0]), .len_ticks(len_gap));

  breath_seq #(.UNIT_LOG2(UNIT_LOG2), .LEN_W(LEN_W), .PWM_BITS(PWM_BITS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .mode_en   (mode_en),
    .upd       (upd),
    .tick      (tick),
    .len_delay (len_delay),
    .len_rise  (len_rise),
    .len_dwell (len_dwell),
    .len_fall  (len_fall),
    .len_gap   (len_gap),
    .rise_code (codes_q[13:11]),
    .fall_code (codes_q[6:4]),
    .phase     (phase),
    .duty      (duty),
    .mode_q    (mode_q)
  );

  breath_pwm #(.PWM_BITS(PWM_BITS)) u_pwm (
    .clk     (clk),
    .rst     (rst),
    .duty    (duty),
    .sink_en (sink_en)
  );

endmodule

// File: rtl/breath_pwm_engine_chk.sv
module breath_pwm_engine_chk
  import breath_pkg::*;
#(
  parameter int PWM_BITS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_en,
  input logic              upd,
  input logic              sink_en,
  input phase_t            phase,
  input logic [PWM_BITS:0] duty,
  input logic              mode_q,
  input logic [17:0]       codes_q
);

  assert_dark_when_off_R1: assert property (@(posedge clk) disable iff (rst)
    !mode_en |=> ##1 !sink_en);

  assert_holdoff_dark_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HOLD) |=> !sink_en);

  assert_holdoff_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HOLD && $past(phase) != PH_HOLD) |-> ($past(upd) || !$past(mode_q)));

  assert_rise_monotonic_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RISE && $past(phase) == PH_RISE) |-> (duty >= $past(duty)));

  assert_dwell_full_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HIGH) |=> sink_en);

  assert_fall_monotonic_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FALL && $past(phase) == PH_FALL) |-> (duty <= $past(duty)));

  assert_gap_dark_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOW) |=> !sink_en);

  assert_rise_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RISE && $past(phase) != PH_RISE) |->
      ($past(phase) == PH_HOLD || $past(phase) == PH_FALL || $past(phase) == PH_LOW));

  assert_codes_only_on_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(codes_q));

endmodule

bind breath_pwm_engine breath_pwm_engine_chk #(.PWM_BITS(PWM_BITS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mode_en (mode_en),
  .upd     (upd),
  .sink_en (sink_en),
  .phase   (phase),
  .duty    (duty),
  .mode_q  (mode_q),
  .codes_q (codes_q)
);

// File: tb/sim_breath_pwm_engine.sv
`timescale 1ns/1ps
module sim_breath_pwm_engine;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       mode_en = 1'b0;
  logic       upd = 1'b0;
  logic [3:0] delay_code = 4'd0;
  logic [2:0] rise_code = 3'd0;
  logic [3:0] dwell_code = 4'd0;
  logic [2:0] fall_code = 3'd0;
  logic [3:0] gap_code = 4'd0;
  logic       sink_en;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Model codes: the ones the engine is expected to be using.
  int m0 = 0, m1 = 0, m2 = 0, m3 = 0, m4 = 0;

  int gtab[32] = '{0,1,3,5,8,12,16,21,26,32,38,45,52,60,68,76,
                   85,95,105,115,125,136,148,160,172,185,198,211,225,239,254,255};

  always #4 clk = ~clk;

  breath_pwm_engine u0 (
    .clk(clk), .rst(rst), .tick(tick), .mode_en(mode_en), .upd(upd),
    .delay_code(delay_code), .rise_code(rise_code), .dwell_code(dwell_code),
    .fall_code(fall_code), .gap_code(gap_code), .sink_en(sink_en)
  );

  function automatic int hold_len(int code, int mx);
    int k = (code > mx) ? mx : code;
    return (k == 0) ? 0 : (32 << (k - 1));
  endfunction

  function automatic int ramp_len(int code);
    return 32 << code;
  endfunction

  function automatic int exp_duty(int p);
    int l0 = hold_len(m0, 10);
    int l1 = ramp_len(m1);
    int l2 = hold_len(m2, 8);
    int l3 = ramp_len(m3);
    int l4 = hold_len(m4, 10);
    int q;
    if (p < l0) return 0;
    q = (p - l0) % (l1 + l2 + l3 + l4);
    if (q < l1) return gtab[q / (l1 / 32)];
    q -= l1;
    if (q < l2) return 256;
    q -= l2;
    if (q < l3) return gtab[31 - q / (l3 / 32)];
    return 0;
  endfunction

  function automatic string phase_req(int p);
    int l0 = hold_len(m0, 10);
    int l1 = ramp_len(m1);
    int l2 = hold_len(m2, 8);
    int l3 = ramp_len(m3);
    int l4 = hold_len(m4, 10);
    int q;
    if (p < l0) return "R2";
    q = (p - l0) % (l1 + l2 + l3 + l4);
    if (q < l1) return "R3";
    if (q < l1 + l2) return "R4";
    if (q < l1 + l2 + l3) return "R5";
    return "R6";
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk); upd = 1'b1;
    @(negedge clk); upd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // One tick, then count sink_en over the 256 cycles that carry the new duty.
  task automatic run_slow(input int first_p, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int ones = 0;
      int p = first_p + i + 1;
      tick = 1'b1;
      @(posedge clk);
      @(negedge clk); tick = 1'b0;
      repeat (256) begin
        @(posedge clk);
        @(negedge clk);
        if (sink_en) ones++;
      end
      chk(ones == exp_duty(p), {tag, " ", phase_req(p)}, ones, exp_duty(p));
    end
  endtask

  task automatic count_high(input int ncyc, output int ones);
    ones = 0;
    repeat (ncyc) begin
      @(negedge clk);
      if (sink_en) ones++;
    end
  endtask

  task automatic longest_run(input bit val, input int ncyc, output int best);
    int cur = 0;
    best = 0;
    repeat (ncyc) begin
      @(negedge clk);
      if (sink_en == val) cur++; else cur = 0;
      if (cur > best) best = cur;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int ones;
    int run;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state, disabled output stays dark.
    count_high(300, ones);
    chk(ones == 0, "R1 reset dark", ones, 0);

    // R1/R8: mode entry with no strobe uses reset codes (all zero).
    @(negedge clk); mode_en = 1'b1;
    repeat (2) @(negedge clk);
    run_slow(0, 70, "R8 reset-codes");

    // R10 with holdoff, ramps, dwell and gap all present.
    delay_code = 4'd1; rise_code = 3'd0; dwell_code = 4'd1; fall_code = 3'd0; gap_code = 4'd1;
    m0 = 1; m1 = 0; m2 = 1; m3 = 0; m4 = 1;
    strobe();
    run_slow(0, 170, "R10");

    // R7: new input codes without a strobe change nothing.
    delay_code = 4'd3; rise_code = 3'd2; dwell_code = 4'd0; fall_code = 3'd1; gap_code = 4'd0;
    run_slow(170, 20, "R7 no-strobe");

    // R6/R4: zero dwell and zero gap are skipped, two-tick ramp steps.
    delay_code = 4'd0; rise_code = 3'd1; dwell_code = 4'd0; fall_code = 3'd0; gap_code = 4'd0;
    m0 = 0; m1 = 1; m2 = 0; m3 = 0; m4 = 0;
    strobe();
    run_slow(0, 100, "R6 skip");

    // R1: disabling darkens the output.
    @(negedge clk); mode_en = 1'b0;
    repeat (2) @(negedge clk);
    count_high(300, ones);
    chk(ones == 0, "R1 disabled dark", ones, 0);

    // R8: re-entry restarts with the captured codes, not the pins.
    delay_code = 4'd2; rise_code = 3'd3; dwell_code = 4'd5; fall_code = 3'd3; gap_code = 4'd5;
    @(negedge clk); mode_en = 1'b1;
    repeat (2) @(negedge clk);
    run_slow(0, 10, "R8 re-entry");

    // R9: dwell code 12 acts as 8 -> 128 units = 4096 ticks fully on.
    delay_code = 4'd0; rise_code = 3'd0; dwell_code = 4'd12; fall_code = 3'd0; gap_code = 4'd0;
    strobe();
    tick = 1'b1;
    longest_run(1'b1, 4400, run);
    chk(run >= 4096 && run <= 4160, "R9 dwell saturation", run, 4096);
    @(negedge clk); tick = 1'b0;

    // R9: gap code 13 acts as 10 -> 512 units = 16384 ticks dark.
    dwell_code = 4'd0; gap_code = 4'd13;
    strobe();
    tick = 1'b1;
    longest_run(1'b0, 16700, run);
    chk(run >= 16384 && run <= 16448, "R9 gap saturation", run, 16384);
    @(negedge clk); tick = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end

endmodule